// File: doc/BRIEF.md
# Flash Hardware Reset Sequencer

This block sits behind the active-low reset pin of a flash device. It passes the pin through a synchronizer and measures how long the pin stays low. A low pulse shorter than the minimum width is dropped and has no effect. A pulse that reaches the minimum width counts as a real reset. The block then aborts any internal program or erase routine, returns the command state machine to asynchronous read mode, turns off the data output drivers and refuses commands. It keeps the device not-ready until it has recovered.

Recovery has two conditions, and both must be met. The first is a recovery count that starts at the abort. The count is long when the internal program/erase engine was busy when the synchronized pin first went low, and short otherwise. The second is a hold count that starts when the released pin is seen high. All analog timings are given as cycle-count parameters. The outputs are plain control levels. The block has no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `flash_rst_seq`

## Requirements
- R1: When `rst_n` is asserted, asynchronously and at any time, the block returns to idle: `ready_o`=1, `dq_oe_o`=1, `cmd_block_o`=0, `fsm_reset_o`=0, `abort_o`=0.
- R2: A pin low lasting at least TRP_CYC clock cycles qualifies as a reset. `abort_o` is then high for exactly one cycle, starting TRP_CYC+SYNC_STAGES rising edges after the pin falls.
- R3: A pin low lasting fewer than TRP_CYC cycles changes no output at any time.
- R4: From the abort cycle until ready returns, `dq_oe_o`=0, `ready_o`=0 and `cmd_block_o`=1.
- R5: `fsm_reset_o` is 1 from the abort cycle until SYNC_STAGES+1 edges after the pin rises, and 0 at all other times.
- R6: The recovery count is REC_BUSY_CYC cycles when `eng_busy_i` was 1 at the edge where the synchronized pin was first seen low. It is REC_IDLE_CYC cycles otherwise. `ready_o` stays 0 for at least that many cycles after the abort cycle begins.
- R7: `ready_o` stays 0 for at least TRH_CYC cycles after the release is seen, which happens SYNC_STAGES+1 edges after the pin rises.
- R8: `ready_o` and `dq_oe_o` return to 1, and `cmd_block_o` returns to 0, on the later of the two bounds in R6 and R7, and no later.
- R9: Changes on `eng_busy_i` after the falling-edge sample do not change which recovery count is used.
- R10: A new pin low of any length during recovery brings `fsm_reset_o` back to 1 after SYNC_STAGES+1 edges, without a second abort pulse. The recovery count keeps running, and the hold count restarts at the next release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Block logic reset, active low, asynchronous |
| pin_rst_n | input | 1 | Raw device reset pin, active low, asynchronous to clk |
| eng_busy_i | input | 1 | Internal program/erase engine busy |
| abort_o | output | 1 | One-cycle pulse that ends the running internal routine |
| dq_oe_o | output | 1 | Data output driver enable; 0 forces high impedance |
| cmd_block_o | output | 1 | Command decoder must ignore bus writes and reads |
| fsm_reset_o | output | 1 | Holds the command state machine in asynchronous read mode |
| ready_o | output | 1 | Device readable (1) or recovering (0) |

## Verification
Every result is counted in rising edges from the falling-edge edit of the pin, which the bench drives on a falling clock edge. The abort pulse is due on edge TRP_CYC+SYNC_STAGES. `fsm_reset_o` clears SYNC_STAGES+1 edges after the release. Ready is due on the later of the abort edge plus the recovery count and the seen-release edge plus TRH_CYC. The bench walks each scenario one edge at a time. At every edge it compares all five outputs with the value the formula gives, sampling at the following falling clock edge, so a result that comes one edge early or one edge late is reported as a mismatch.

// File: rtl/flash_rst_pkg.sv
package flash_rst_pkg;
  // Sequencer phases: idle, measuring a low pulse, reset held, released and recovering
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_QUAL = 2'd1,
    ST_HELD = 2'd2,
    ST_REL  = 2'd3
  } rst_state_e;
endpackage

// File: rtl/frst_sync.sv
module frst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES < 2) begin : g_single
      logic ff;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff <= 1'b1;
        else        ff <= d;
      end
      assign q = ff;
    end else begin : g_chain
      logic [STAGES-1:0] ff;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff <= '1;
        else        ff <= {ff[STAGES-2:0], d};
      end
      assign q = ff[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/frst_countdown.sv
module frst_countdown #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (load)               cnt <= load_val;
    else if (run && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  // R6: once expired, a count stays expired until the next load
  assert_count_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> done);
endmodule

// File: rtl/frst_ctrl.sv
module frst_ctrl
  import flash_rst_pkg::*;
#(
  parameter int TRP_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_s,
  input  logic       busy,
  input  logic       rec_done,
  input  logic       hold_done,
  output rst_state_e state,
  output logic       busy_cap,
  output logic       rec_load,
  output logic       rec_run,
  output logic       hold_load,
  output logic       hold_run,
  output logic       abort_o
);
  localparam int LW = $clog2(TRP_CYC + 1);

  rst_state_e    nxt;
  logic [LW-1:0] low_cnt;
  logic          qual_hit;

  always_comb begin
    nxt       = state;
    qual_hit  = 1'b0;
    hold_load = 1'b0;
    case (state)
      ST_IDLE: if (!pin_s) nxt = ST_QUAL;
      ST_QUAL: begin
        if (pin_s) nxt = ST_IDLE;
        else if (low_cnt == LW'(TRP_CYC - 1)) begin
          nxt      = ST_HELD;
          qual_hit = 1'b1;
        end
      end
      ST_HELD: if (pin_s) begin
        nxt       = ST_REL;
        hold_load = 1'b1;
      end
      ST_REL: begin
        if (!pin_s) nxt = ST_HELD;
        else if (rec_done && hold_done) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      low_cnt  <= '0;
      busy_cap <= 1'b0;
      abort_o  <= 1'b0;
    end else begin
      state   <= nxt;
      abort_o <= qual_hit;
      if (state == ST_IDLE)      low_cnt <= LW'(1);
      else if (state == ST_QUAL) low_cnt <= low_cnt + 1'b1;
      if (state == ST_IDLE && !pin_s) busy_cap <= busy;
    end
  end

  assign rec_load = qual_hit;
  assign rec_run  = (state == ST_HELD) || (state == ST_REL);
  assign hold_run = (state == ST_REL);

  // R2: the abort is a single-cycle pulse
  assert_abort_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> !abort_o);
  // R3: an abort only follows a synchronized low level
  assert_abort_after_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> !$past(pin_s));
endmodule

// File: rtl/flash_rst_seq.sv
module flash_rst_seq
  import flash_rst_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int TRP_CYC      = 4,
  parameter int REC_BUSY_CYC = 40,
  parameter int REC_IDLE_CYC = 10,
  parameter int TRH_CYC      = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_rst_n,
  input  logic eng_busy_i,
  output logic abort_o,
  output logic dq_oe_o,
  output logic cmd_block_o,
  output logic fsm_reset_o,
  output logic ready_o
);
  localparam int REC_MAX = (REC_BUSY_CYC > REC_IDLE_CYC) ? REC_BUSY_CYC : REC_IDLE_CYC;
  localparam int CNT_MAX = (REC_MAX > TRH_CYC) ? REC_MAX : TRH_CYC;
  localparam int CW      = $clog2(CNT_MAX + 1);

  logic       pin_s;
  rst_state_e state;
  logic       busy_cap, rec_load, rec_run, hold_load, hold_run;
  logic       rec_done, hold_done;
  logic [CW-1:0] rec_val;

  frst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_rst_n), .q(pin_s)
  );

  frst_ctrl #(.TRP_CYC(TRP_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .busy(eng_busy_i),
    .rec_done(rec_done), .hold_done(hold_done),
    .state(state), .busy_cap(busy_cap), .rec_load(rec_load), .rec_run(rec_run),
    .hold_load(hold_load), .hold_run(hold_run), .abort_o(abort_o)
  );

  assign rec_val = busy_cap ? CW'(REC_BUSY_CYC - 1) : CW'(REC_IDLE_CYC - 1);

  frst_countdown #(.W(CW)) u_rec_cnt (
    .clk(clk), .rst_n(rst_n), .load(rec_load), .load_val(rec_val),
    .run(rec_run), .done(rec_done)
  );

  frst_countdown #(.W(CW)) u_hold_cnt (
    .clk(clk), .rst_n(rst_n), .load(hold_load), .load_val(CW'(TRH_CYC - 1)),
    .run(hold_run), .done(hold_done)
  );

  assign ready_o     = (state == ST_IDLE) || (state == ST_QUAL);
  assign dq_oe_o     = ready_o;
  assign cmd_block_o = (state == ST_HELD) || (state == ST_REL);
  assign fsm_reset_o = (state == ST_HELD);

  // R7: ready only returns after the synchronized pin was seen high
  assert_ready_after_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> $past(pin_s));
  // R6: ready only returns once the recovery count has expired
  assert_ready_after_recovery_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> $past(rec_done));
endmodule

// File: tb/flash_rst_seq_tb.sv
module flash_rst_seq_tb;
  localparam int SYNC = 2;
  localparam int TRP  = 4;
  localparam int RB   = 40;
  localparam int RI   = 10;
  localparam int TRH  = 6;

  typedef struct packed {
    int   low_len;
    logic busy0;
    logic busy1;
    int   relow_at;
    int   relow_len;
    int   req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{3,  1'b1, 1'b1, 0,  0,  3},   // R3 one cycle short of qualifying
    '{1,  1'b0, 1'b0, 0,  0,  3},   // R3 single-cycle glitch
    '{4,  1'b0, 1'b0, 0,  0,  2},   // R2 minimum width, engine idle
    '{4,  1'b1, 1'b1, 0,  0,  6},   // R6 engine busy, long recovery
    '{30, 1'b0, 1'b0, 0,  0,  7},   // R7 release hold dominates
    '{4,  1'b1, 1'b0, 0,  0,  9},   // R9 busy drops after the sample
    '{4,  1'b0, 1'b1, 0,  0,  9},   // R9 busy rises after the sample
    '{60, 1'b1, 1'b1, 0,  0,  8},   // R8 later bound is the release hold
    '{4,  1'b1, 1'b1, 10, 2,  10},  // R10 short re-low during recovery
    '{4,  1'b0, 1'b0, 10, 10, 10}   // R10 long re-low extends ready
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_n = 1'b1;
  logic busy = 1'b0;
  logic abort_o, dq_oe_o, cmd_block_o, fsm_reset_o, ready_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  flash_rst_seq u_dut (
    .clk(clk), .rst_n(rst_n), .pin_rst_n(pin_n), .eng_busy_i(busy),
    .abort_o(abort_o), .dq_oe_o(dq_oe_o), .cmd_block_o(cmd_block_o),
    .fsm_reset_o(fsm_reset_o), .ready_o(ready_o)
  );

  function automatic logic [4:0] outs();
    return {abort_o, fsm_reset_o, cmd_block_o, dq_oe_o, ready_o};
  endfunction

  task automatic check(input bit ok, input int req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    bit qual;
    int rt, e0, r1, rlast, rdy, last, mism, aborts, frel;
    logic [4:0] got, exp, fgot, fexp;
    qual  = (v.low_len >= TRP);
    rt    = v.busy0 ? RB : RI;
    e0    = TRP + SYNC;
    r1    = v.low_len + SYNC + 1;
    rlast = (v.relow_at > 0) ? v.relow_at + v.relow_len + SYNC + 1 : r1;
    rdy   = (e0 + rt > rlast + TRH) ? e0 + rt : rlast + TRH;
    last  = qual ? rdy + 3 : v.low_len + SYNC + 4;
    mism = 0; aborts = 0; frel = 0; fgot = '0; fexp = '0;
    @(negedge clk);
    pin_n = 1'b0;
    busy  = v.busy0;
    for (int rel = 1; rel <= last; rel++) begin
      @(negedge clk);
      exp[4] = qual && (rel == e0);
      exp[3] = qual && ((rel >= e0 && rel < r1) ||
               (v.relow_at > 0 && rel >= v.relow_at + SYNC + 1 && rel < rlast));
      exp[2] = qual && (rel >= e0) && (rel < rdy);
      exp[1] = !exp[2];
      exp[0] = !exp[2];
      got = outs();
      if (got !== exp) begin
        if (mism == 0) begin frel = rel; fgot = got; fexp = exp; end
        mism++;
      end
      if (abort_o) aborts++;
      if (rel == v.low_len) pin_n = 1'b1;
      if (rel == SYNC + 1) busy = v.busy1;
      if (v.relow_at > 0 && rel == v.relow_at) pin_n = 1'b0;
      if (v.relow_at > 0 && rel == v.relow_at + v.relow_len) pin_n = 1'b1;
    end
    // waveform covers R4 R5 R8 timing as well as the row's own requirement
    if (mism != 0) $display("  first mismatch at edge %0d", frel);
    check(mism == 0, v.req, "outputs {abort,fsm_rst,blk,oe,rdy} R4 R5 R8", fgot, fexp);
    check(aborts == (qual ? 1 : 0), v.req, "abort pulse count R2", aborts, qual ? 1 : 0);
    busy = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(outs() === 5'b00011, 1, "reset state R1", outs(), 5'b00011);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R1: block reset in the middle of a held reset returns to idle at once
    pin_n = 1'b0;
    busy  = 1'b1;
    repeat (10) @(negedge clk);
    check(fsm_reset_o === 1'b1, 1, "held before block reset R1", fsm_reset_o, 1);
    rst_n = 1'b0;
    #1;
    check(outs() === 5'b00011, 1, "async block reset R1", outs(), 5'b00011);
    pin_n = 1'b1;
    busy  = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(outs() === 5'b00011, 1, "idle after block reset R1", outs(), 5'b00011);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule